// File: doc/BRIEF.md
# Configurable Pin Bank with Interrupt Detection

This block controls a bank of general-purpose pins (32 by default). Four configuration bits per pin decide what each pin does. It can be a sensed interrupt source, an input to one of four peripheral functions, a software-driven output, or a software-read input. The block drives the output value and output enable for each pin. It also produces a 2-bit peripheral select and a pull-enable for each pin, and one combined interrupt request.

Software reaches the bank through a single-cycle register port. The address holds a 3-bit register index and a 2-bit operation code. Writes to a configuration register go only through its set or clear alias, so one pin can be changed without a read-modify-write. The pad inputs pass through a two-flop synchronizer. The synchronized levels feed the edge and level detectors and the level readback register. Detected conditions are held in a sticky pending register until software clears them.

Top module: `pinbank_ctrl`

## Requirements
- R1: The address is {index[2:0], op[1:0]}. The indices are: 0 interrupt-select, 1 gate, 2 pattern-high, 3 pattern-low, 4 pending, 5 pull-off and 6 level (read only). Op 1 sets every bit where wdata is 1 and op 2 clears every bit where wdata is 1; bits with wdata 0 are unchanged. A write with op 0 or 3, or to index 6 or 7, changes nothing. A read returns the indexed register for any op; index 7 reads zero. rdata is combinational.
- R2: A pin with interrupt-select=1 is an interrupt input whatever its gate bit is. It drives pad_oe=0, pad_out=0, alt_en=0 and alt_sel=0.
- R3: A pin with interrupt-select=0 and gate=0 is in peripheral mode. It drives alt_en=1, alt_sel={pattern-high, pattern-low} (bits 2i+1:2i), pad_oe=0 and pad_out=0. In every other mode alt_en=0 and alt_sel=0.
- R4: A pin with interrupt-select=0, gate=1 and pattern-high=0 is an output. It drives pad_oe=1 and pad_out=pattern-low.
- R5: A pin with interrupt-select=0, gate=1 and pattern-high=1 is an input. It drives pad_oe=0 and pad_out=0.
- R6: An interrupt pin with pattern-high=1 detects an edge of its synchronized level. The edge is rising when pattern-low is 1 and falling when it is 0. A pad change before clock edge k sets the pending bit at edge k+2. The bit then stays set until it is cleared through the pending clear alias.
- R7: An interrupt pin with pattern-high=0 sets its pending bit on every cycle that its synchronized level equals pattern-low. Detection takes priority over a clear written in the same cycle.
- R8: irq is the OR, over all pins, of pending AND interrupt-select AND NOT gate. A gated pin still latches its pending bit.
- R9: The level register returns pad_in delayed by two clock edges, for every pin in every mode.
- R10: pull_en for each pin equals NOT pull-off.
- R11: After reset, every configuration register, the pending register and the synchronizer are zero. Every pin is therefore in peripheral function 0 with its pull enabled and irq low.
- R12: Only pins with interrupt-select=1 set pending bits in hardware. Software may also set pending bits through the pending set alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | {register index, operation} |
| wdata | input | NPINS | Write mask, one bit per pin |
| rdata | output | NPINS | Read data for the addressed register |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Output value per pin |
| pad_oe | output | NPINS | Output enable per pin |
| alt_en | output | NPINS | Pin is in peripheral mode |
| alt_sel | output | 2*NPINS | Peripheral function number per pin |
| pull_en | output | NPINS | Pull resistor enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the points where the mode decode and the detectors interact. A gated interrupt pin must still latch its pending bit; a design that stops latching would lose the request when the gate opens. A level-triggered pin is cleared while its level is still active; a design that lets the clear win would show a one-cycle gap in pending and irq. The bench also pulses edges on pins whose polarity is the opposite one, and pulses them on non-interrupt pins. It checks that a write with op 0 or 3, or a write to the level register, changes nothing. A decoder that honours the gate bit in interrupt mode, or mislatches edges, would fail the clock-by-clock comparison with the reference model.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned IDX_W  = 3;
    localparam int unsigned OP_W   = 2;
    localparam int unsigned ADDR_W = IDX_W + OP_W;

    typedef enum logic [IDX_W-1:0] {
        RG_IRQSEL  = 3'd0,
        RG_GATE    = 3'd1,
        RG_PATHI   = 3'd2,
        RG_PATLO   = 3'd3,
        RG_PEND    = 3'd4,
        RG_PULLOFF = 3'd5,
        RG_LEVEL   = 3'd6,
        RG_NONE    = 3'd7
    } reg_idx_e;

    typedef enum logic [OP_W-1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } reg_op_e;

    typedef enum logic [1:0] {
        PM_IRQ = 2'd0,
        PM_ALT = 2'd1,
        PM_GPO = 2'd2,
        PM_GPI = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);

    typedef struct packed {
        logic [NPINS-1:0] stage1;
        logic [NPINS-1:0] stage2;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = pad_in;
        sync_d.stage2 = sync_q.stage1;
        sync_d.prev   = sync_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level = sync_q.stage2;
    assign rise  = sync_q.stage2 & ~sync_q.prev;
    assign fall  = ~sync_q.stage2 & sync_q.prev;

endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0]   cfg_irq,
    input  logic [NPINS-1:0]   cfg_gate,
    input  logic [NPINS-1:0]   cfg_phi,
    input  logic [NPINS-1:0]   cfg_plo,
    input  logic [NPINS-1:0]   level,
    input  logic [NPINS-1:0]   rise,
    input  logic [NPINS-1:0]   fall,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   alt_en,
    output logic [2*NPINS-1:0] alt_sel,
    output logic [NPINS-1:0]   det
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e mode;
        logic      hit;

        always_comb begin
            if (cfg_irq[i]) begin
                mode = PM_IRQ;
            end else if (!cfg_gate[i]) begin
                mode = PM_ALT;
            end else if (cfg_phi[i]) begin
                mode = PM_GPI;
            end else begin
                mode = PM_GPO;
            end
        end

        always_comb begin
            if (cfg_phi[i]) begin
                hit = cfg_plo[i] ? rise[i] : fall[i];
            end else begin
                hit = (level[i] == cfg_plo[i]);
            end
        end

        assign pad_oe[i]          = (mode == PM_GPO);
        assign pad_out[i]         = (mode == PM_GPO) && cfg_plo[i];
        assign alt_en[i]          = (mode == PM_ALT);
        assign alt_sel[2*i+1 -: 2] = (mode == PM_ALT) ? {cfg_phi[i], cfg_plo[i]} : 2'b00;
        assign det[i]             = (mode == PM_IRQ) && hit;
    end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  det,
    input  logic [NPINS-1:0]  level,
    output logic [NPINS-1:0]  cfg_irq,
    output logic [NPINS-1:0]  cfg_gate,
    output logic [NPINS-1:0]  cfg_phi,
    output logic [NPINS-1:0]  cfg_plo,
    output logic [NPINS-1:0]  pend,
    output logic [NPINS-1:0]  pull_off,
    output logic [NPINS-1:0]  rdata
);

    localparam int unsigned NREGS = 6;

    typedef struct packed {
        logic [NPINS-1:0] irqsel;
        logic [NPINS-1:0] gate;
        logic [NPINS-1:0] pathi;
        logic [NPINS-1:0] patlo;
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] pulloff;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_idx_e idx;
    reg_op_e  op;

    logic [NREGS-1:0][NPINS-1:0] set_m;
    logic [NREGS-1:0][NPINS-1:0] clr_m;

    assign idx = reg_idx_e'(addr[ADDR_W-1:OP_W]);
    assign op  = reg_op_e'(addr[OP_W-1:0]);

    for (genvar r = 0; r < NREGS; r++) begin : g_mask
        logic hit;
        assign hit      = wr_en && (idx == reg_idx_e'(r));
        assign set_m[r] = (hit && op == OP_SET) ? wdata : '0;
        assign clr_m[r] = (hit && op == OP_CLR) ? wdata : '0;
    end

    always_comb begin
        regs_d         = regs_q;
        regs_d.irqsel  = (regs_q.irqsel  & ~clr_m[RG_IRQSEL])  | set_m[RG_IRQSEL];
        regs_d.gate    = (regs_q.gate    & ~clr_m[RG_GATE])    | set_m[RG_GATE];
        regs_d.pathi   = (regs_q.pathi   & ~clr_m[RG_PATHI])   | set_m[RG_PATHI];
        regs_d.patlo   = (regs_q.patlo   & ~clr_m[RG_PATLO])   | set_m[RG_PATLO];
        regs_d.pulloff = (regs_q.pulloff & ~clr_m[RG_PULLOFF]) | set_m[RG_PULLOFF];
        // hardware detection wins over a same-cycle clear
        regs_d.pend    = (regs_q.pend & ~clr_m[RG_PEND]) | set_m[RG_PEND] | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (idx)
            RG_IRQSEL:  rdata = regs_q.irqsel;
            RG_GATE:    rdata = regs_q.gate;
            RG_PATHI:   rdata = regs_q.pathi;
            RG_PATLO:   rdata = regs_q.patlo;
            RG_PEND:    rdata = regs_q.pend;
            RG_PULLOFF: rdata = regs_q.pulloff;
            RG_LEVEL:   rdata = level;
            default:    rdata = '0;
        endcase
    end

    assign cfg_irq  = regs_q.irqsel;
    assign cfg_gate = regs_q.gate;
    assign cfg_phi  = regs_q.pathi;
    assign cfg_plo  = regs_q.patlo;
    assign pend     = regs_q.pend;
    assign pull_off = regs_q.pulloff;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [4:0]         addr,
    input  logic [NPINS-1:0]   wdata,
    output logic [NPINS-1:0]   rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   alt_en,
    output logic [2*NPINS-1:0] alt_sel,
    output logic [NPINS-1:0]   pull_en,
    output logic               irq
);

    logic [NPINS-1:0] level, rise, fall, det;
    logic [NPINS-1:0] cfg_irq, cfg_gate, cfg_phi, cfg_plo, pend, pull_off;

    pinbank_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    pinbank_decode #(.NPINS(NPINS)) u_decode (
        .cfg_irq  (cfg_irq),
        .cfg_gate (cfg_gate),
        .cfg_phi  (cfg_phi),
        .cfg_plo  (cfg_plo),
        .level    (level),
        .rise     (rise),
        .fall     (fall),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .alt_en   (alt_en),
        .alt_sel  (alt_sel),
        .det      (det)
    );

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .det      (det),
        .level    (level),
        .cfg_irq  (cfg_irq),
        .cfg_gate (cfg_gate),
        .cfg_phi  (cfg_phi),
        .cfg_plo  (cfg_plo),
        .pend     (pend),
        .pull_off (pull_off),
        .rdata    (rdata)
    );

    assign pull_en = ~pull_off;
    assign irq     = |(pend & cfg_irq & ~cfg_gate);

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [4:0]       addr,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] alt_en,
    input logic             irq,
    input logic [NPINS-1:0] cfg_irq,
    input logic [NPINS-1:0] cfg_gate,
    input logic [NPINS-1:0] cfg_plo,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] level
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_OE_ALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & alt_en) == '0); // R3

    AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & pad_oe) == (cfg_plo & pad_oe)); // R4

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & cfg_irq & ~cfg_gate) == '0) |-> !irq); // R8

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {RG_PEND, OP_CLR}) |=> ((pend & $past(wdata & ~cfg_irq)) == '0)); // R6

    AST_LEVEL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (level == $past(pad_in, 2))); // R9

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_irq)); // R1

    AST_NO_OUT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_irq & (pad_oe | alt_en)) == '0)); // R2

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .alt_en   (alt_en),
    .irq      (irq),
    .cfg_irq  (cfg_irq),
    .cfg_gate (cfg_gate),
    .cfg_plo  (cfg_plo),
    .pend     (pend),
    .level    (level)
);

// File: tb/pinbank_ctrl_test.sv
`timescale 1ns/1ps
module pinbank_ctrl_test;

    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [4:0]     addr = '0;
    logic [N-1:0]   wdata = '0;
    logic [N-1:0]   rdata;
    logic [N-1:0]   pad_in = '0;
    logic [N-1:0]   pad_out, pad_oe, alt_en, pull_en;
    logic [2*N-1:0] alt_sel;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pinbank_ctrl #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_en(alt_en), .alt_sel(alt_sel), .pull_en(pull_en), .irq(irq)
    );

    // reference model: index 0..5 hold the writable registers
    logic [N-1:0] m_reg [0:5];
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    initial for (int r = 0; r < 6; r++) m_reg[r] = '0;

    always @(posedge clk) begin
        logic [N-1:0] hit;
        int ix, op;
        if (!rst_n) begin
            for (int r = 0; r < 6; r++) m_reg[r] = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            hit = '0;
            for (int i = 0; i < N; i++) begin
                if (m_reg[0][i]) begin
                    if (m_reg[2][i])
                        hit[i] = m_reg[3][i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
                    else
                        hit[i] = (m_s2[i] == m_reg[3][i]);
                end
            end
            ix = int'(addr[4:2]);
            op = int'(addr[1:0]);
            if (wr_en && ix < 6) begin
                if (op == 1) m_reg[ix] = m_reg[ix] | wdata;
                if (op == 2) m_reg[ix] = m_reg[ix] & ~wdata;
            end
            m_reg[4] = m_reg[4] | hit;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [N-1:0] e_out, e_oe, e_alt, e_rd;
        logic [2*N-1:0] e_sel;
        int ix;
        if (!done) begin
            e_out = '0; e_oe = '0; e_alt = '0; e_sel = '0;
            for (int i = 0; i < N; i++) begin
                if (m_reg[0][i]) begin
                end else if (!m_reg[1][i]) begin
                    e_alt[i] = 1'b1;
                    e_sel[2*i] = m_reg[3][i];
                    e_sel[2*i+1] = m_reg[2][i];
                end else if (!m_reg[2][i]) begin
                    e_oe[i] = 1'b1;
                    e_out[i] = m_reg[3][i];
                end
            end
            ix = int'(addr[4:2]);
            e_rd = (ix < 6) ? m_reg[ix] : (ix == 6) ? m_s2 : '0;
            chk("R4 pad_out", {{N{1'b0}}, pad_out}, {{N{1'b0}}, e_out});
            chk("R2/R5 pad_oe", {{N{1'b0}}, pad_oe}, {{N{1'b0}}, e_oe});
            chk("R3 alt_en", {{N{1'b0}}, alt_en}, {{N{1'b0}}, e_alt});
            chk("R3 alt_sel", alt_sel, e_sel);
            chk("R10 pull_en", {{N{1'b0}}, pull_en}, {{N{1'b0}}, ~m_reg[5]});
            chk("R8 irq", {{(2*N-1){1'b0}}, irq}, {{(2*N-1){1'b0}}, |(m_reg[4] & m_reg[0] & ~m_reg[1])});
            if (ix == 4)      chk("R6/R7/R12 pending", {{N{1'b0}}, rdata}, {{N{1'b0}}, e_rd});
            else if (ix == 6) chk("R9 level", {{N{1'b0}}, rdata}, {{N{1'b0}}, e_rd});
            else              chk("R1 rdata", {{N{1'b0}}, rdata}, {{N{1'b0}}, e_rd});
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
            addr = {3'(k % 8), 2'd0};
        end
    endtask

    task automatic wr(input int ix, input int op, input logic [N-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = {3'(ix), 2'(op)}; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = {3'(ix), 2'd0}; wdata = '0;
    endtask

    task automatic pad(input int p, input logic v);
        @(posedge clk); #1;
        pad_in[p] = v;
    endtask

    initial begin
        idle(3);
        @(posedge clk); #1; rst_n = 1'b1;
        // R11: every register reads zero after reset
        for (int ix = 0; ix < 8; ix++) begin
            @(posedge clk); #1;
            addr = {3'(ix), 2'd0};
            #0.5;
            chk("R11 reset", {{N{1'b0}}, rdata}, '0);
        end
        chk("R11 irq", {{(2*N-1){1'b0}}, irq}, '0);

        // gpio: pin3 output high, pin4 input, pin5 peripheral 2
        wr(1, 1, 32'h0000_0018);
        wr(3, 1, 32'h0000_0008);
        wr(2, 1, 32'h0000_0030);
        wr(5, 1, 32'h0000_0010);
        // ignored writes: op 0, op 3, level register (R1)
        wr(0, 0, '1); wr(1, 3, '1); wr(6, 1, '1); wr(7, 1, '1);
        idle(4);
        // interrupts: pin7 rising, pin8 falling, pin9 level high, pin10 gated level low
        wr(2, 1, 32'h0000_0180);
        wr(3, 1, 32'h0000_0280);
        wr(1, 1, 32'h0000_0400);
        wr(0, 1, 32'h0000_0780);
        idle(4);
        wr(4, 2, '1);
        pad(7, 1); idle(5); pad(7, 0); idle(5);   // R6 rising only
        wr(4, 2, 32'h0000_0080);
        pad(8, 1); idle(5); pad(8, 0); idle(5);   // R6 falling only
        pad(9, 1); idle(3);
        wr(4, 2, 32'h0000_0200); idle(3);         // R7 clear loses to level
        pad(9, 0); wr(4, 2, 32'h0000_0200); idle(3);
        wr(1, 2, 32'h0000_0400); idle(3);         // R8 ungating shows latched bit
        pad(11, 1); idle(4); pad(11, 0); idle(4); // R12 non-interrupt pin
        wr(4, 1, 32'h0001_0000); idle(3);         // R12 software set
        wr(4, 2, '1); idle(3);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); #1;
            if (($urandom % 4) == 0) begin
                wr_en = 1'b1;
                addr = 5'($urandom);
                wdata = $urandom & $urandom;
            end else begin
                wr_en = 1'b0;
                addr = {3'($urandom), 2'd0};
            end
            if (($urandom % 3) == 0) pad_in = pad_in ^ ($urandom & $urandom & $urandom);
        end
        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule